// File: doc/BRIEF.md
# Inter-Bank Command Spacing Checker

This block sits beside a DDR SDRAM command sequencer and judges each registered command against the spacing that a read or write with auto precharge imposes on the other banks. Every clock it sees one command (an operation code, a bank number and an auto-precharge flag). In the same cycle it raises either a grant or a violation flag. Three configuration inputs set the spacing: a burst-length code, the CAS latency in half-clock units and a write-to-read turnaround in clocks.

Each bank holds one down-counter per command class (read, write, precharge, activate). A granted auto-precharge access loads the counters of the bank it addresses. A command to a bank is blocked while any counter of its class in some other bank is still nonzero. For every class the block also brings out the largest counter across the banks, which is the number of clocks until that class is free again for any bank.

Top module: `ibsc_spacing_chk`

## Requirements
- R1: While reset is low, all four wait outputs read zero. The first command after reset is judged against clear counters.
- R2: The NOP (code 0) and DESELECT (code 1) operations raise neither grant nor violation. They only let the counters count down.
- R3: After a granted write with auto precharge, a read to any other bank is flagged until 1 + BL/2 + turnaround clocks have passed since the write.
- R4: After a granted write with auto precharge, a write to any other bank is flagged until BL/2 clocks have passed.
- R5: After a granted read with auto precharge, a read to any other bank is flagged until BL/2 clocks have passed.
- R6: After a granted read with auto precharge, a write to any other bank is flagged until ceil(CL) + BL/2 clocks have passed. CL is given in half clocks, so code 5 means 3 clocks and code 4 means 2.
- R7: With the default gap parameter of 1, PRECHARGE (code 5) and ACTIVE (code 2) are never flagged, even in the cycle right after an auto-precharge access.
- R8: A command to the same bank as the earlier access is not checked. REFRESH (code 6) and LOAD MODE (code 7) are not checked either and are always granted. Accesses without auto precharge load no counters.
- R9: A command that is flagged as a violation loads no counters.
- R10: Each wait output equals the largest pending counter of its class across the banks. Without a new load it falls by one per clock until it reaches zero.
- R11: Burst-length code 0 selects BL 2, code 1 selects BL 4, and codes 2 and 3 select BL 8.
- R12: For operation codes 2 to 7, exactly one of grant and violation is high, in the same cycle as the command. READ is code 3 and WRITE is code 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 3 | Operation code of the current command |
| cmd_bank | input | BANK_W | Bank addressed by the command |
| cmd_ap | input | 1 | Auto-precharge flag of a read or write |
| cfg_bl_sel | input | 2 | Burst-length code |
| cfg_cl_half | input | CL_W | CAS latency in half clocks |
| cfg_wtr | input | WTR_W | Write-to-read turnaround in clocks |
| cmd_grant | output | 1 | Command is legal |
| cmd_viol | output | 1 | Command breaks an inter-bank spacing rule |
| rd_wait | output | CNT_W | Clocks until reads are free |
| wr_wait | output | CNT_W | Clocks until writes are free |
| pre_wait | output | CNT_W | Clocks until precharges are free |
| act_wait | output | CNT_W | Clocks until activates are free |

## Verification
The hardest case to reach is a command that is both blocked and itself an auto-precharge access. If it were wrongly recorded, it would silently extend the wait of a class other than the one it broke. The stimulus issues a write with auto precharge and then, in the very next cycle, a second auto-precharge write to another bank. It then reads the read wait in the following cycle: this shows whether the wait still counts down from the first write or was reloaded by the second. The rounding of a fractional CAS latency and the reserved burst code are reached by changing the configuration between otherwise identical short sequences, with idle cycles in between so that no counter carries over.

// File: rtl/ibsc_pkg.sv
package ibsc_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_DESEL = 3'd1,
    OP_ACT   = 3'd2,
    OP_RD    = 3'd3,
    OP_WR    = 3'd4,
    OP_PRE   = 3'd5,
    OP_REF   = 3'd6,
    OP_LMR   = 3'd7
  } ibsc_op_e;

  localparam int NUM_CLS = 4;
  localparam int CLS_RD  = 0;
  localparam int CLS_WR  = 1;
  localparam int CLS_PRE = 2;
  localparam int CLS_ACT = 3;

  // half of the burst length, from the burst code
  function automatic logic [3:0] burst_half(input logic [1:0] sel);
    case (sel)
      2'd0:    burst_half = 4'd1;
      2'd1:    burst_half = 4'd2;
      default: burst_half = 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/ibsc_cmd_decode.sv
module ibsc_cmd_decode
  import ibsc_pkg::*;
(
  input  logic [2:0] op_i,
  input  logic       ap_i,
  output logic       is_cmd_o,
  output logic       chk_en_o,
  output logic [1:0] cls_o,
  output logic       ap_access_o,
  output logic       src_wr_o
);

  ibsc_op_e op;

  always_comb begin
    op          = ibsc_op_e'(op_i);
    is_cmd_o    = 1'b1;
    chk_en_o    = 1'b0;
    cls_o       = 2'(CLS_RD);
    ap_access_o = 1'b0;
    src_wr_o    = 1'b0;
    case (op)
      OP_NOP, OP_DESEL: is_cmd_o = 1'b0;
      OP_RD: begin
        chk_en_o    = 1'b1;
        cls_o       = 2'(CLS_RD);
        ap_access_o = ap_i;
      end
      OP_WR: begin
        chk_en_o    = 1'b1;
        cls_o       = 2'(CLS_WR);
        ap_access_o = ap_i;
        src_wr_o    = 1'b1;
      end
      OP_PRE: begin
        chk_en_o = 1'b1;
        cls_o    = 2'(CLS_PRE);
      end
      OP_ACT: begin
        chk_en_o = 1'b1;
        cls_o    = 2'(CLS_ACT);
      end
      default: chk_en_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/ibsc_gap_calc.sv
module ibsc_gap_calc
  import ibsc_pkg::*;
#(
  parameter int CL_W   = 4,
  parameter int WTR_W  = 3,
  parameter int CNT_W  = 5,
  parameter int PA_GAP = 1
) (
  input  logic [1:0]       bl_sel_i,
  input  logic [CL_W-1:0]  cl_half_i,
  input  logic [WTR_W-1:0] wtr_i,
  input  logic             src_wr_i,
  output logic [CNT_W-1:0] load_o [NUM_CLS]
);

  localparam logic [CNT_W-1:0] PA_LOAD = CNT_W'(PA_GAP - 1);

  logic [CNT_W-1:0] bh;
  logic [CNT_W-1:0] clru;
  logic [CNT_W-1:0] wtr_x;
  logic [CL_W:0]    cl_up;

  always_comb begin
    bh    = CNT_W'(burst_half(bl_sel_i));
    cl_up = ({1'b0, cl_half_i} + {{CL_W{1'b0}}, 1'b1}) >> 1;
    clru  = CNT_W'(cl_up);
    wtr_x = CNT_W'(wtr_i);
    if (src_wr_i) begin
      // gap is 1 + BL/2 + wtr; counter holds gap - 1
      load_o[CLS_RD] = bh + wtr_x;
      load_o[CLS_WR] = bh - CNT_W'(1);
    end else begin
      load_o[CLS_RD] = bh - CNT_W'(1);
      load_o[CLS_WR] = clru + bh - CNT_W'(1);
    end
    load_o[CLS_PRE] = PA_LOAD;
    load_o[CLS_ACT] = PA_LOAD;
  end

endmodule

// File: rtl/ibsc_bank_timer.sv
module ibsc_bank_timer
  import ibsc_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_hit_i,
  input  logic [CNT_W-1:0] load_val_i [NUM_CLS],
  output logic [CNT_W-1:0] cnt_o      [NUM_CLS]
);

  logic [CNT_W-1:0] cnt_q [NUM_CLS];
  logic [CNT_W-1:0] cnt_d [NUM_CLS];
  logic [CNT_W-1:0] dec   [NUM_CLS];
  logic             en    [NUM_CLS];

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    always_comb begin
      dec[c] = (cnt_q[c] != '0) ? cnt_q[c] - CNT_W'(1) : '0;
      en[c]  = load_hit_i || (cnt_q[c] != '0);
      if (load_hit_i && (load_val_i[c] > dec[c])) cnt_d[c] = load_val_i[c];
      else                                         cnt_d[c] = dec[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q[c] <= '0;
      else if (en[c]) cnt_q[c] <= cnt_d[c];
    end

    assign cnt_o[c] = cnt_q[c];
  end

endmodule

// File: rtl/ibsc_verdict.sv
module ibsc_verdict
  import ibsc_pkg::*;
#(
  parameter int NB     = 4,
  parameter int BANK_W = 2,
  parameter int CNT_W  = 5
) (
  input  logic [CNT_W-1:0]  cnt_i [NB][NUM_CLS],
  input  logic [BANK_W-1:0] bank_i,
  input  logic [1:0]        cls_i,
  output logic              blocked_o,
  output logic [CNT_W-1:0]  wait_o [NUM_CLS]
);

  always_comb begin
    blocked_o = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if ((BANK_W'(b) != bank_i) && (cnt_i[b][cls_i] != '0)) blocked_o = 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_max
    always_comb begin
      wait_o[c] = '0;
      for (int b = 0; b < NB; b++) begin
        if (cnt_i[b][c] > wait_o[c]) wait_o[c] = cnt_i[b][c];
      end
    end
  end

endmodule

// File: rtl/ibsc_spacing_chk.sv
module ibsc_spacing_chk
  import ibsc_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int CL_W   = 4,
  parameter int WTR_W  = 3,
  parameter int PA_GAP = 1,
  parameter int CNT_W  = $clog2(4 + (2 ** WTR_W) + (2 ** (CL_W - 1)) + PA_GAP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              cmd_ap,
  input  logic [1:0]        cfg_bl_sel,
  input  logic [CL_W-1:0]   cfg_cl_half,
  input  logic [WTR_W-1:0]  cfg_wtr,
  output logic              cmd_grant,
  output logic              cmd_viol,
  output logic [CNT_W-1:0]  rd_wait,
  output logic [CNT_W-1:0]  wr_wait,
  output logic [CNT_W-1:0]  pre_wait,
  output logic [CNT_W-1:0]  act_wait
);

  localparam int NB = 2 ** BANK_W;

  logic             is_cmd;
  logic             chk_en;
  logic [1:0]       cls;
  logic             ap_access;
  logic             src_wr;
  logic             blocked;
  logic [CNT_W-1:0] load_v  [NUM_CLS];
  logic [CNT_W-1:0] cnt_all [NB][NUM_CLS];
  logic [CNT_W-1:0] wmax    [NUM_CLS];
  logic [NB-1:0]    hit;

  ibsc_cmd_decode u_dec (
    .op_i        (cmd_op),
    .ap_i        (cmd_ap),
    .is_cmd_o    (is_cmd),
    .chk_en_o    (chk_en),
    .cls_o       (cls),
    .ap_access_o (ap_access),
    .src_wr_o    (src_wr)
  );

  ibsc_gap_calc #(
    .CL_W   (CL_W),
    .WTR_W  (WTR_W),
    .CNT_W  (CNT_W),
    .PA_GAP (PA_GAP)
  ) u_gap (
    .bl_sel_i  (cfg_bl_sel),
    .cl_half_i (cfg_cl_half),
    .wtr_i     (cfg_wtr),
    .src_wr_i  (src_wr),
    .load_o    (load_v)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign hit[b] = ap_access && cmd_grant && (cmd_bank == BANK_W'(b));

    ibsc_bank_timer #(
      .CNT_W (CNT_W)
    ) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_hit_i (hit[b]),
      .load_val_i (load_v),
      .cnt_o      (cnt_all[b])
    );
  end

  ibsc_verdict #(
    .NB     (NB),
    .BANK_W (BANK_W),
    .CNT_W  (CNT_W)
  ) u_vrd (
    .cnt_i     (cnt_all),
    .bank_i    (cmd_bank),
    .cls_i     (cls),
    .blocked_o (blocked),
    .wait_o    (wmax)
  );

  always_comb begin
    cmd_viol  = is_cmd && chk_en && blocked;
    cmd_grant = is_cmd && !cmd_viol;
    rd_wait   = wmax[CLS_RD];
    wr_wait   = wmax[CLS_WR];
    pre_wait  = wmax[CLS_PRE];
    act_wait  = wmax[CLS_ACT];
  end

endmodule

// File: rtl/ibsc_spacing_sva.sv
module ibsc_spacing_sva #(
  parameter int BANK_W = 2,
  parameter int PA_GAP = 1,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cmd_op,
  input logic              cmd_ap,
  input logic [1:0]        cfg_bl_sel,
  input logic              cmd_grant,
  input logic              cmd_viol,
  input logic [CNT_W-1:0]  rd_wait,
  input logic [CNT_W-1:0]  wr_wait
);

  logic       ap_load;
  logic [3:0] bh;

  always_comb begin
    ap_load = cmd_grant && cmd_ap && ((cmd_op == 3'd3) || (cmd_op == 3'd4));
    bh      = (cfg_bl_sel == 2'd0) ? 4'd1 : (cfg_bl_sel == 2'd1) ? 4'd2 : 4'd4;
  end

  // R2
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op <= 3'd1) |-> (!cmd_grant && !cmd_viol));

  // R12
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op >= 3'd2) |-> (cmd_grant != cmd_viol));

  // R10
  rd_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_wait != '0) && !ap_load) |=> (rd_wait == $past(rd_wait) - CNT_W'(1)));

  // R10
  wr_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_wait != '0) && !ap_load) |=> (wr_wait == $past(wr_wait) - CNT_W'(1)));

  // R5
  rda_rd_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_load && (cmd_op == 3'd3)) |=> (32'(rd_wait) >= 32'($past(bh)) - 1));

  // R4
  wra_wr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_load && (cmd_op == 3'd4)) |=> (32'(wr_wait) >= 32'($past(bh)) - 1));

  // R7
  pa_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((PA_GAP == 1) && ((cmd_op == 3'd2) || (cmd_op == 3'd5))) |-> !cmd_viol);

endmodule

bind ibsc_spacing_chk ibsc_spacing_sva #(
  .BANK_W (BANK_W),
  .PA_GAP (PA_GAP),
  .CNT_W  (CNT_W)
) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_op     (cmd_op),
  .cmd_ap     (cmd_ap),
  .cfg_bl_sel (cfg_bl_sel),
  .cmd_grant  (cmd_grant),
  .cmd_viol   (cmd_viol),
  .rd_wait    (rd_wait),
  .wr_wait    (wr_wait)
);

// File: tb/ibsc_spacing_chk_tb.sv
module ibsc_spacing_chk_tb;

  localparam int BANK_W = 2;
  localparam int CL_W   = 4;
  localparam int WTR_W  = 3;
  localparam int CNT_W  = $clog2(4 + (2 ** WTR_W) + (2 ** (CL_W - 1)) + 1);

  // {op[2:0], bank[1:0], ap, grant, viol, rd_wait[3:0], wr_wait[3:0]}
  // config: burst code 1 (BL 4), CL code 5 (3 clocks), turnaround 2
  localparam int NV = 12;
  localparam logic [15:0] VEC [NV] = '{
    {3'd4, 2'd0, 1'b1, 1'b1, 1'b0, 4'd0, 4'd0},
    {3'd3, 2'd1, 1'b0, 1'b0, 1'b1, 4'd4, 4'd1},
    {3'd4, 2'd1, 1'b0, 1'b1, 1'b0, 4'd3, 4'd0},
    {3'd2, 2'd2, 1'b0, 1'b1, 1'b0, 4'd2, 4'd0},
    {3'd3, 2'd1, 1'b0, 1'b0, 1'b1, 4'd1, 4'd0},
    {3'd3, 2'd1, 1'b1, 1'b1, 1'b0, 4'd0, 4'd0},
    {3'd3, 2'd0, 1'b0, 1'b0, 1'b1, 4'd1, 4'd4},
    {3'd3, 2'd2, 1'b0, 1'b1, 1'b0, 4'd0, 4'd3},
    {3'd4, 2'd3, 1'b0, 1'b0, 1'b1, 4'd0, 4'd2},
    {3'd4, 2'd1, 1'b0, 1'b1, 1'b0, 4'd0, 4'd1},
    {3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0},
    {3'd4, 2'd3, 1'b0, 1'b1, 1'b0, 4'd0, 4'd0}
  };

  logic              clk;
  logic              rst_n;
  logic [2:0]        cmd_op;
  logic [BANK_W-1:0] cmd_bank;
  logic              cmd_ap;
  logic [1:0]        cfg_bl_sel;
  logic [CL_W-1:0]   cfg_cl_half;
  logic [WTR_W-1:0]  cfg_wtr;
  logic              cmd_grant;
  logic              cmd_viol;
  logic [CNT_W-1:0]  rd_wait;
  logic [CNT_W-1:0]  wr_wait;
  logic [CNT_W-1:0]  pre_wait;
  logic [CNT_W-1:0]  act_wait;

  int checks;
  int fails;

  ibsc_spacing_chk u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_op      (cmd_op),
    .cmd_bank    (cmd_bank),
    .cmd_ap      (cmd_ap),
    .cfg_bl_sel  (cfg_bl_sel),
    .cfg_cl_half (cfg_cl_half),
    .cfg_wtr     (cfg_wtr),
    .cmd_grant   (cmd_grant),
    .cmd_viol    (cmd_viol),
    .rd_wait     (rd_wait),
    .wr_wait     (wr_wait),
    .pre_wait    (pre_wait),
    .act_wait    (act_wait)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [1:0] bank, input logic ap);
    @(negedge clk);
    cmd_op   = op;
    cmd_bank = bank;
    cmd_ap   = ap;
    #1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(3'd0, 2'd0, 1'b0);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    checks      = 0;
    fails       = 0;
    rst_n       = 1'b0;
    cmd_op      = 3'd0;
    cmd_bank    = '0;
    cmd_ap      = 1'b0;
    cfg_bl_sel  = 2'd1;
    cfg_cl_half = 4'd5;
    cfg_wtr     = 3'd2;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 rd_wait in reset", int'(rd_wait), 0);
    chk("R1 wr_wait in reset", int'(wr_wait), 0);
    chk("R1 pre_wait in reset", int'(pre_wait), 0);
    chk("R1 act_wait in reset", int'(act_wait), 0);
    chk("R2 NOP grant in reset", int'(cmd_grant), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // table: R3/R4/R5/R6/R8/R10 under BL 4, CL 3, turnaround 2
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][15:13], VEC[i][12:11], VEC[i][10]);
      chk($sformatf("R3/R4/R5/R6/R8 table grant step %0d", i), int'(cmd_grant), int'(VEC[i][9]));
      chk($sformatf("R3/R4/R5/R6/R8 table viol step %0d", i), int'(cmd_viol), int'(VEC[i][8]));
      chk($sformatf("R10 table rd_wait step %0d", i), int'(rd_wait), int'(VEC[i][7:4]));
      chk($sformatf("R10 table wr_wait step %0d", i), int'(wr_wait), int'(VEC[i][3:0]));
    end

    // reset mid-run, long turnaround
    cfg_wtr = 3'd7;
    drive(3'd4, 2'd0, 1'b1);
    drive(3'd0, 2'd0, 1'b0);
    chk("R3 rd_wait after write-ap wtr 7", int'(rd_wait), 9);
    chk("R4 wr_wait after write-ap BL4", int'(wr_wait), 1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 rd_wait cleared by reset", int'(rd_wait), 0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(3'd3, 2'd1, 1'b0);
    chk("R1 read granted after reset", int'(cmd_grant), 1);

    // BL 8, turnaround 0
    cfg_bl_sel = 2'd2;
    cfg_wtr    = 3'd0;
    drive(3'd4, 2'd0, 1'b1);
    chk("R4 write-ap granted", int'(cmd_grant), 1);
    drive(3'd4, 2'd1, 1'b0);
    chk("R4 write too early BL8", int'(cmd_viol), 1);
    chk("R11 wr_wait BL8 code 2", int'(wr_wait), 3);
    drive(3'd0, 2'd0, 1'b0);
    drive(3'd1, 2'd0, 1'b0);
    chk("R2 DESELECT no grant", int'(cmd_grant), 0);
    chk("R2 DESELECT no viol", int'(cmd_viol), 0);
    chk("R10 wr_wait counts down", int'(wr_wait), 1);
    drive(3'd4, 2'd1, 1'b0);
    chk("R4 write at BL/2 gap granted", int'(cmd_grant), 1);
    chk("R3 rd_wait one left", int'(rd_wait), 1);
    drive(3'd3, 2'd2, 1'b0);
    chk("R3 read at 1+BL/2+wtr granted", int'(cmd_grant), 1);
    idle(2);

    // reserved burst code
    cfg_bl_sel = 2'd3;
    drive(3'd4, 2'd0, 1'b1);
    drive(3'd0, 2'd0, 1'b0);
    chk("R11 wr_wait code 3 acts as BL8", int'(wr_wait), 3);
    chk("R11 rd_wait code 3 acts as BL8", int'(rd_wait), 4);
    idle(6);

    // CL rounding, BL 2
    cfg_bl_sel  = 2'd0;
    cfg_cl_half = 4'd5;
    drive(3'd3, 2'd0, 1'b1);
    drive(3'd3, 2'd1, 1'b0);
    chk("R5 read one clock after read-ap BL2", int'(cmd_grant), 1);
    chk("R6 wr_wait CL 2.5 rounds to 3", int'(wr_wait), 3);
    idle(5);
    cfg_cl_half = 4'd4;
    drive(3'd3, 2'd0, 1'b1);
    drive(3'd4, 2'd1, 1'b0);
    chk("R6 write too early CL 2", int'(cmd_viol), 1);
    chk("R6 wr_wait CL 2", int'(wr_wait), 2);
    drive(3'd0, 2'd0, 1'b0);
    drive(3'd4, 2'd1, 1'b0);
    chk("R6 write at CL+BL/2 granted", int'(cmd_grant), 1);
    idle(2);

    // violating access not recorded, unchecked commands
    cfg_bl_sel = 2'd1;
    cfg_wtr    = 3'd2;
    drive(3'd4, 2'd0, 1'b1);
    drive(3'd4, 2'd1, 1'b1);
    chk("R4 second write-ap flagged", int'(cmd_viol), 1);
    drive(3'd6, 2'd2, 1'b0);
    chk("R9 rd_wait not reloaded by flagged write", int'(rd_wait), 3);
    chk("R9 wr_wait not reloaded by flagged write", int'(wr_wait), 0);
    chk("R8 refresh granted while read blocked", int'(cmd_grant), 1);
    drive(3'd3, 2'd0, 1'b0);
    chk("R8 same-bank read granted", int'(cmd_grant), 1);
    drive(3'd2, 2'd3, 1'b0);
    chk("R7 activate granted during spacing", int'(cmd_grant), 1);
    drive(3'd4, 2'd2, 1'b1);
    drive(3'd5, 2'd3, 1'b0);
    chk("R7 precharge right after write-ap", int'(cmd_grant), 1);
    chk("R7 pre_wait stays zero", int'(pre_wait), 0);
    drive(3'd7, 2'd1, 1'b0);
    chk("R8 load mode granted", int'(cmd_grant), 1);
    chk("R12 load mode no viol", int'(cmd_viol), 0);
    idle(6);

    finish_run();
  end

endmodule